// File: doc/BRIEF.md
# Direct-Page Effective Address Generator

This block turns the operand bytes of a memory-referencing instruction into a 16-bit effective address for an 8-bit processor. The sequencer opens an access by presenting a one-bit addressing mode on a command channel. The block then takes one operand byte in direct mode or two in absolute mode from an operand byte stream. It returns the address together with the length of the instruction in bytes and the clock cycles it costs.

In direct mode the single operand byte is the low half of the address. The high half comes from an 8-bit page register. That register clears to zero at reset, so direct mode starts out as plain zero-page addressing. The sequencer can load it at any time to move the short-address window to any 256-byte page. Each access takes a copy of the page register when its command is accepted. A load made while an access is in flight therefore applies only from the next access onward.

All three channels use valid/ready handshakes. A transfer happens on a rising clock edge where both valid and ready are high. The command channel is ready only when the block is idle. The operand channel is ready only while a byte is awaited. Once the result is valid it stays valid, with every result field unchanged, until the consumer raises `ea_ready`. No new command is accepted before that. The page-register load pins are plain control with no handshake.

Top module: `dp_addr_gen`

## Requirements
- R1: After reset `cmd_ready` is 1, `opnd_ready` is 0, `ea_valid` is 0, and the page register holds 0x00, so the first direct access with operand byte B yields address 0x00BB.
- R2: In direct mode (`cmd_mode` = 0) exactly one operand byte is consumed. The result address is {page register value captured at command acceptance, operand byte}, with the page in bits 15:8.
- R3: A direct-mode result reports `ea_len` = 2 and `ea_cycles` = 3.
- R4: In absolute mode (`cmd_mode` = 1) exactly two operand bytes are consumed. The first is the low byte (bits 7:0) and the second is the high byte (bits 15:8). The page register has no effect on the result.
- R5: An absolute-mode result reports `ea_len` = 3 and `ea_cycles` = 4.
- R6: A pulse on `page_load` with `page_value` = P makes P the page for every direct access whose command is accepted on a later clock edge.
- R7: A page load on or after the edge that accepts a command does not change that access's address. The next direct access uses the new page.
- R8: While `ea_valid` is 1 and `ea_ready` is 0, `ea_valid` stays 1 and `ea_addr`, `ea_len` and `ea_cycles` hold their values. `cmd_ready` stays 0 until the result is taken.
- R9: `opnd_ready` is 1 only between command acceptance and the last operand byte. A byte offered on the operand channel while the block is idle is not consumed and does not reach the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_mode | input | 1 | 0 = direct page, 1 = absolute |
| opnd_valid | input | 1 | Operand byte offered |
| opnd_ready | output | 1 | Block awaits an operand byte |
| opnd_data | input | 8 | Operand byte |
| page_load | input | 1 | Load the page register this cycle |
| page_value | input | 8 | New page register value |
| ea_valid | output | 1 | Result available |
| ea_ready | input | 1 | Consumer takes the result |
| ea_addr | output | 16 | Effective address |
| ea_len | output | 2 | Instruction length in bytes |
| ea_cycles | output | 3 | Clock cycles for the access |

## Verification
A corrupted page register shows up only in bits 15:8 of a later direct-mode result. A stale or early snapshot appears on the first direct access after a mid-flight load, about three handshakes after the load. A sequencer state that is wrong shows at once on the ready pins, in the cycle after the faulty edge. An operand byte that is swapped or consumed twice shows as misplaced address bytes or a missing result. A mode latched wrongly shows as a length and cycle pair that does not match the number of bytes consumed.

// File: rtl/dpag_pkg.sv
package dpag_pkg;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_ABS    = 1'b1
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_OUT  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/dpag_page_reg.sv
module dpag_page_reg #(
  parameter int PAGE_W     = 8,
  parameter int RESET_PAGE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] value,
  output logic [PAGE_W-1:0] page
);

  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    page_q <= PAGE_W'(RESET_PAGE);
    else if (load) page_q <= value;
  end

  assign page = page_q;

endmodule

// File: rtl/dpag_cost.sv
module dpag_cost
  import dpag_pkg::*;
#(
  parameter int LEN_W   = 2,
  parameter int CYC_W   = 3,
  parameter int DIR_LEN = 2,
  parameter int DIR_CYC = 3,
  parameter int ABS_LEN = 3,
  parameter int ABS_CYC = 4
) (
  input  amode_e           mode,
  output logic [LEN_W-1:0] len,
  output logic [CYC_W-1:0] cycles
);

  always_comb begin
    if (mode == MODE_ABS) begin
      len    = LEN_W'(ABS_LEN);
      cycles = CYC_W'(ABS_CYC);
    end else begin
      len    = LEN_W'(DIR_LEN);
      cycles = CYC_W'(DIR_CYC);
    end
  end

endmodule

// File: rtl/dpag_collector.sv
module dpag_collector
  import dpag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  amode_e            cmd_mode,
  input  logic [DATA_W-1:0] page,
  input  logic              opnd_valid,
  output logic              opnd_ready,
  input  logic [DATA_W-1:0] opnd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output amode_e            res_mode,
  output logic [ADDR_W-1:0] res_addr
);

  seq_state_e        state_q;
  amode_e            mode_q;
  logic [DATA_W-1:0] snap_q;
  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] addr_q;

  assign cmd_ready  = (state_q == ST_IDLE);
  assign opnd_ready = (state_q == ST_LO) || (state_q == ST_HI);
  assign res_valid  = (state_q == ST_OUT);
  assign res_mode   = mode_q;
  assign res_addr   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_DIRECT;
      snap_q  <= '0;
      lo_q    <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid) begin
          mode_q  <= cmd_mode;
          snap_q  <= page;
          state_q <= ST_LO;
        end
        ST_LO: if (opnd_valid) begin
          if (mode_q == MODE_DIRECT) begin
            addr_q  <= {snap_q, opnd_data};
            state_q <= ST_OUT;
          end else begin
            lo_q    <= opnd_data;
            state_q <= ST_HI;
          end
        end
        ST_HI: if (opnd_valid) begin
          addr_q  <= {opnd_data, lo_q};
          state_q <= ST_OUT;
        end
        ST_OUT: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dp_addr_gen.sv
module dp_addr_gen
  import dpag_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RESET_PAGE = 0,
  parameter int DIR_LEN    = 2,
  parameter int DIR_CYC    = 3,
  parameter int ABS_LEN    = 3,
  parameter int ABS_CYC    = 4,
  localparam int ADDR_W    = 2 * DATA_W,
  localparam int LEN_W     = $clog2(ABS_LEN + 1),
  localparam int CYC_W     = $clog2(ABS_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_mode,
  input  logic              opnd_valid,
  output logic              opnd_ready,
  input  logic [DATA_W-1:0] opnd_data,
  input  logic              page_load,
  input  logic [DATA_W-1:0] page_value,
  output logic              ea_valid,
  input  logic              ea_ready,
  output logic [ADDR_W-1:0] ea_addr,
  output logic [LEN_W-1:0]  ea_len,
  output logic [CYC_W-1:0]  ea_cycles
);

  logic [DATA_W-1:0] page_w;
  amode_e            res_mode_w;
  amode_e            cmd_mode_e;

  assign cmd_mode_e = amode_e'(cmd_mode);

  dpag_page_reg #(
    .PAGE_W     (DATA_W),
    .RESET_PAGE (RESET_PAGE)
  ) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (page_load),
    .value (page_value),
    .page  (page_w)
  );

  dpag_collector #(
    .DATA_W (DATA_W)
  ) u_coll (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_mode   (cmd_mode_e),
    .page       (page_w),
    .opnd_valid (opnd_valid),
    .opnd_ready (opnd_ready),
    .opnd_data  (opnd_data),
    .res_valid  (ea_valid),
    .res_ready  (ea_ready),
    .res_mode   (res_mode_w),
    .res_addr   (ea_addr)
  );

  dpag_cost #(
    .LEN_W   (LEN_W),
    .CYC_W   (CYC_W),
    .DIR_LEN (DIR_LEN),
    .DIR_CYC (DIR_CYC),
    .ABS_LEN (ABS_LEN),
    .ABS_CYC (ABS_CYC)
  ) u_cost (
    .mode   (res_mode_w),
    .len    (ea_len),
    .cycles (ea_cycles)
  );

endmodule

// File: rtl/dpag_checker.sv
module dpag_checker #(
  parameter int DATA_W     = 8,
  parameter int RESET_PAGE = 0,
  parameter int DIR_LEN    = 2,
  parameter int DIR_CYC    = 3,
  parameter int ABS_LEN    = 3,
  parameter int ABS_CYC    = 4,
  localparam int ADDR_W    = 2 * DATA_W,
  localparam int LEN_W     = $clog2(ABS_LEN + 1),
  localparam int CYC_W     = $clog2(ABS_CYC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_mode,
  input logic              opnd_valid,
  input logic              opnd_ready,
  input logic [DATA_W-1:0] opnd_data,
  input logic              page_load,
  input logic [DATA_W-1:0] page_value,
  input logic              ea_valid,
  input logic              ea_ready,
  input logic [ADDR_W-1:0] ea_addr,
  input logic [LEN_W-1:0]  ea_len,
  input logic [CYC_W-1:0]  ea_cycles
);

  // Independent tracking of page and first operand byte
  logic [DATA_W-1:0] mir_page_q, mir_snap_q, mir_first_q;
  logic              mir_abs_q, mir_got_first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mir_page_q      <= DATA_W'(RESET_PAGE);
      mir_snap_q      <= '0;
      mir_first_q     <= '0;
      mir_abs_q       <= 1'b0;
      mir_got_first_q <= 1'b0;
    end else begin
      if (page_load) mir_page_q <= page_value;
      if (cmd_valid && cmd_ready) begin
        mir_snap_q      <= mir_page_q;
        mir_abs_q       <= cmd_mode;
        mir_got_first_q <= 1'b0;
      end
      if (opnd_valid && opnd_ready && !mir_got_first_q) begin
        mir_first_q     <= opnd_data;
        mir_got_first_q <= 1'b1;
      end
    end
  end

  assert_dir_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !mir_abs_q) |-> (ea_addr == {mir_snap_q, mir_first_q}));

  assert_dir_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !mir_abs_q) |-> (ea_len == LEN_W'(DIR_LEN) && ea_cycles == CYC_W'(DIR_CYC)));

  assert_abs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && mir_abs_q) |-> (ea_addr[DATA_W-1:0] == mir_first_q));

  assert_abs_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && mir_abs_q) |-> (ea_len == LEN_W'(ABS_LEN) && ea_cycles == CYC_W'(ABS_CYC)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !ea_ready) |=> (ea_valid && $stable(ea_addr) && $stable(ea_len) && $stable(ea_cycles)));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> !cmd_ready);

  assert_opnd_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_ready |-> (!cmd_ready && !ea_valid));

endmodule

bind dp_addr_gen dpag_checker #(
  .DATA_W     (DATA_W),
  .RESET_PAGE (RESET_PAGE),
  .DIR_LEN    (DIR_LEN),
  .DIR_CYC    (DIR_CYC),
  .ABS_LEN    (ABS_LEN),
  .ABS_CYC    (ABS_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_mode   (cmd_mode),
  .opnd_valid (opnd_valid),
  .opnd_ready (opnd_ready),
  .opnd_data  (opnd_data),
  .page_load  (page_load),
  .page_value (page_value),
  .ea_valid   (ea_valid),
  .ea_ready   (ea_ready),
  .ea_addr    (ea_addr),
  .ea_len     (ea_len),
  .ea_cycles  (ea_cycles)
);

// File: tb/dp_addr_gen_bench.sv
`timescale 1ns/1ps
module dp_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_mode = 1'b0;
  logic        cmd_ready;
  logic        opnd_valid = 1'b0;
  logic        opnd_ready;
  logic [7:0]  opnd_data = 8'h00;
  logic        page_load = 1'b0;
  logic [7:0]  page_value = 8'h00;
  logic        ea_valid;
  logic        ea_ready = 1'b0;
  logic [15:0] ea_addr;
  logic [1:0]  ea_len;
  logic [2:0]  ea_cycles;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  dp_addr_gen u_dp_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
    .opnd_valid(opnd_valid), .opnd_ready(opnd_ready), .opnd_data(opnd_data),
    .page_load(page_load), .page_value(page_value),
    .ea_valid(ea_valid), .ea_ready(ea_ready),
    .ea_addr(ea_addr), .ea_len(ea_len), .ea_cycles(ea_cycles)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = m;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    opnd_valid = 1'b1; opnd_data = b;
    while (!opnd_ready) @(negedge clk);
    @(posedge clk); #1;
    opnd_valid = 1'b0;
  endtask

  task automatic load_page(input logic [7:0] p);
    @(negedge clk);
    page_load = 1'b1; page_value = p;
    @(posedge clk); #1;
    page_load = 1'b0;
  endtask

  task automatic take(output logic [15:0] a, output logic [1:0] l, output logic [2:0] c);
    @(negedge clk);
    while (!ea_valid) @(negedge clk);
    a = ea_addr; l = ea_len; c = ea_cycles;
    ea_ready = 1'b1;
    @(posedge clk); #1;
    ea_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] a; logic [1:0] l; logic [2:0] c;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 1);
    check(opnd_ready == 1'b0, "R1 opnd_ready", 32'(opnd_ready), 0);
    check(ea_valid == 1'b0, "R1 ea_valid", 32'(ea_valid), 0);
    send_cmd(1'b0); send_byte(8'h3C); take(a, l, c);
    check(a == 16'h003C, "R1 zero page addr", 32'(a), 32'h003C);
  endtask

  task automatic t_direct;
    logic [15:0] a; logic [1:0] l; logic [2:0] c;
    load_page(8'hA5);
    send_cmd(1'b0); send_byte(8'hFF); take(a, l, c);
    check(a == 16'hA5FF, "R2 R6 direct addr", 32'(a), 32'hA5FF);
    check(l == 2'd2, "R3 direct len", 32'(l), 2);
    check(c == 3'd3, "R3 direct cycles", 32'(c), 3);
    send_cmd(1'b0); send_byte(8'h00); take(a, l, c);
    check(a == 16'hA500, "R2 R6 page persists", 32'(a), 32'hA500);
  endtask

  task automatic t_absolute;
    logic [15:0] a; logic [1:0] l; logic [2:0] c;
    load_page(8'h77);
    send_cmd(1'b1); send_byte(8'h34); send_byte(8'h12); take(a, l, c);
    check(a == 16'h1234, "R4 abs addr low first", 32'(a), 32'h1234);
    check(l == 2'd3, "R5 abs len", 32'(l), 3);
    check(c == 3'd4, "R5 abs cycles", 32'(c), 4);
    send_cmd(1'b1); send_byte(8'hFF); send_byte(8'h00); take(a, l, c);
    check(a == 16'h00FF, "R4 abs ignores page", 32'(a), 32'h00FF);
  endtask

  task automatic t_midflight;
    logic [15:0] a; logic [1:0] l; logic [2:0] c;
    load_page(8'h12);
    send_cmd(1'b0);
    load_page(8'h34);
    send_byte(8'h56); take(a, l, c);
    check(a == 16'h1256, "R7 in-flight load ignored", 32'(a), 32'h1256);
    send_cmd(1'b0); send_byte(8'h78); take(a, l, c);
    check(a == 16'h3478, "R7 next access uses load", 32'(a), 32'h3478);
  endtask

  task automatic t_backpressure;
    logic [15:0] a; logic [1:0] l; logic [2:0] c;
    load_page(8'h40);
    send_cmd(1'b0); send_byte(8'h21);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 1'b1;
    repeat (4) @(negedge clk);
    check(ea_valid == 1'b1, "R8 valid held", 32'(ea_valid), 1);
    check(ea_addr == 16'h4021, "R8 addr held", 32'(ea_addr), 32'h4021);
    check(cmd_ready == 1'b0, "R8 cmd blocked", 32'(cmd_ready), 0);
    cmd_valid = 1'b0;
    take(a, l, c);
    check(l == 2'd2 && c == 3'd3, "R8 cost held", {l, c}, {2'd2, 3'd3});
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8 idle after take", 32'(cmd_ready), 1);
  endtask

  task automatic t_idle_byte;
    logic [15:0] a; logic [1:0] l; logic [2:0] c;
    load_page(8'h00);
    @(negedge clk);
    opnd_valid = 1'b1; opnd_data = 8'hAA;
    repeat (3) @(negedge clk);
    check(opnd_ready == 1'b0, "R9 not ready idle", 32'(opnd_ready), 0);
    opnd_valid = 1'b0;
    send_cmd(1'b0);
    @(negedge clk);
    check(opnd_ready == 1'b1, "R9 ready after cmd", 32'(opnd_ready), 1);
    send_byte(8'h55); take(a, l, c);
    check(a == 16'h0055, "R9 idle byte not consumed", 32'(a), 32'h0055);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_absolute();
    t_midflight();
    t_backpressure();
    t_idle_byte();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule